// File: doc/BRIEF.md
# Preloadable Timer and Event Counter

This block is an up-counter for a microcontroller peripheral. It is 16 bits wide by default and can be built as narrow as 8 bits. It runs in one of three modes. In event mode it counts edges on an external pin. In timer mode it counts the cycles in which an internal tick enable is high. In pulse-width mode it makes a one-shot measurement: it counts ticks for as long as the pin holds its active level. When the counter passes all ones it reloads from a preload register and raises a sticky interrupt flag.

Software reaches the block through a byte-wide register port. When the counter is wider than 8 bits, a shared low-byte holding buffer makes whole-word transfers atomic. Writing the low byte only fills the buffer. Writing the high byte then commits the full preload word in one step. Reading the high byte snapshots the low byte into the same buffer, so a later low-byte read returns the matching half.

Sequencing is handled by a four-state machine. ST_IDLE means stopped. ST_RUN is event or timer counting. ST_ARM waits for the start edge of a pulse. ST_MEAS counts during the pulse. The transitions are:
- any state to ST_IDLE when the run bit is 0 or the mode is hold;
- ST_IDLE or ST_RUN to ST_ARM when pulse mode is running;
- ST_IDLE or any state to ST_RUN when event or timer mode is running;
- ST_ARM to ST_MEAS on the start edge;
- ST_MEAS to ST_IDLE on the return edge, which also clears the run bit.

Top module: `tmr_evt_counter`

## Requirements
- R1: After reset the counter, the preload, the low-byte buffer, the control register and the interrupt flag are all zero, so nothing counts.
- R2: The control register sits at address 2. Bits [1:0] are the mode (00 event, 01 timer, 10 pulse width, 11 hold), bit 2 is the edge select and bit 3 is run. A read returns {4'b0, run, edge, mode}.
- R3: In timer mode with run set, the counter advances by one at each clock edge where tick_en is high. It starts counting on the second clock edge after the control write.
- R4: In event mode with run set, the counter advances once per rising pin edge when edge select is 1, and once per falling pin edge when it is 0. tick_en has no effect in this mode.
- R5: An increment from all ones loads the counter from the preload register instead and sets irq_flag.
- R6: irq_flag stays set until irq_clr is pulsed. When an overflow and irq_clr fall in the same cycle, the flag stays set.
- R7: In pulse-width mode, counting starts on a pin rise when edge select is 1 and on a pin fall when it is 0. The counter adds one for each tick in which the synchronised pin holds the active level. On the return edge counting stops and hardware clears the run bit.
- R8: After a measurement the count is held, and further pin edges are ignored until software sets run again.
- R9: Address 0 is the low data register and address 1 the high data register. A write to address 0 only fills the buffer. A write to address 1 sets the preload to {written byte, buffer}. If run is 0 at that moment the counter is loaded with the same value; otherwise the counter is left unchanged.
- R10: A read of address 1 returns the counter's high byte and copies the counter's low byte into the buffer. A read of address 0 returns the buffer.
- R11: In the 8-bit variant, a write to address 0 sets the preload directly (and the counter too while stopped), and a read of address 0 returns the live count.
- R12: While run is 0 the counter changes only through a preload write, whatever the mode, the pin or tick_en do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when no read is selected |
| pin_in | input | 1 | External event/pulse pin, asynchronous |
| tick_en | input | 1 | Internal timebase tick |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| irq_flag | output | 1 | Sticky overflow interrupt request |

## Verification
Timer mode is driven with seeded random tick patterns from preloads close to all ones. This separates correct gating by tick_en from free running, and it exposes a wrong reload value on overflow. Event mode gets random pin levels with random ticks, under both edge selects. Counting the wrong edge, or letting ticks leak in, changes the total. Pulse mode is tried with pulses of known width under both polarities, plus a second pulse after completion, which separates edge-triggered one-shot behaviour from level-following. Directed sequences cover buffered word access, preload writes while running, simultaneous set and clear of the flag, and the 8-bit variant.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_EVENT = 2'b00,
        MODE_TIMER = 2'b01,
        MODE_PULSE = 2'b10,
        MODE_HOLD  = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_ARM  = 2'b10,
        ST_MEAS = 2'b11
    } tmr_state_e;

    // register layout: [3] run, [2] edge select, [1:0] mode
    typedef struct packed {
        logic      run;
        logic      edge_sel;
        tmr_mode_e mode;
    } tmr_ctrl_t;

    localparam logic [1:0] ADR_LO  = 2'd0;
    localparam logic [1:0] ADR_HI  = 2'd1;
    localparam logic [1:0] ADR_CTL = 2'd2;

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_rise,
    output logic pin_fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              lvl;

    assign lvl = sync_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_async};
            prev_q <= lvl;
        end
    end

    assign pin_rise = lvl & ~prev_q;
    assign pin_fall = ~lvl & prev_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [WIDTH-1:0] cnt,
    input  logic             run_clr,
    output tmr_ctrl_t        ctrl_q,
    output logic [WIDTH-1:0] pre_q,
    output logic             pre_wr,
    output logic [WIDTH-1:0] pre_val
);
    logic wr_hit;
    logic rd_hit;

    assign wr_hit = bus_sel & bus_wr;
    assign rd_hit = bus_sel & bus_rd;

    // control register; a software write outranks the hardware run clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_hit && bus_addr == ADR_CTL) begin
            ctrl_q <= tmr_ctrl_t'(bus_wdata[3:0]);
        end else if (run_clr) begin
            ctrl_q.run <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (pre_wr) begin
            pre_q <= pre_val;
        end
    end

    generate
        if (WIDTH > 8) begin : g_wide
            logic [7:0] lo_buf_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lo_buf_q <= '0;
                end else if (wr_hit && bus_addr == ADR_LO) begin
                    lo_buf_q <= bus_wdata;
                end else if (rd_hit && bus_addr == ADR_HI) begin
                    lo_buf_q <= cnt[7:0];
                end
            end

            assign pre_wr  = wr_hit && (bus_addr == ADR_HI);
            assign pre_val = {bus_wdata[WIDTH-9:0], lo_buf_q};

            always_comb begin
                bus_rdata = '0;
                if (rd_hit) begin
                    unique case (bus_addr)
                        ADR_LO:  bus_rdata = lo_buf_q;
                        ADR_HI:  bus_rdata = 8'(cnt[WIDTH-1:8]);
                        ADR_CTL: bus_rdata = {4'b0, ctrl_q};
                        default: bus_rdata = '0;
                    endcase
                end
            end
        end else begin : g_narrow
            assign pre_wr  = wr_hit && (bus_addr == ADR_LO);
            assign pre_val = bus_wdata[WIDTH-1:0];

            always_comb begin
                bus_rdata = '0;
                if (rd_hit) begin
                    unique case (bus_addr)
                        ADR_LO:  bus_rdata = 8'(cnt);
                        ADR_CTL: bus_rdata = {4'b0, ctrl_q};
                        default: bus_rdata = '0;
                    endcase
                end
            end
        end
    endgenerate
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_ctrl_t        ctrl,
    input  logic             tick_en,
    input  logic             pin_rise,
    input  logic             pin_fall,
    input  logic [WIDTH-1:0] pre_q,
    input  logic             pre_wr,
    input  logic [WIDTH-1:0] pre_val,
    input  logic             irq_clr,
    output logic [WIDTH-1:0] cnt_q,
    output tmr_state_e       state_q,
    output logic             run_clr,
    output logic             ovf,
    output logic             irq_flag
);
    localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

    tmr_state_e state_d;
    logic       start_edge;
    logic       stop_edge;
    logic       step;

    assign start_edge = ctrl.edge_sel ? pin_rise : pin_fall;
    assign stop_edge  = ctrl.edge_sel ? pin_fall : pin_rise;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = ST_IDLE;
        if (ctrl.run) begin
            unique case (ctrl.mode)
                MODE_EVENT, MODE_TIMER: state_d = ST_RUN;
                MODE_PULSE: begin
                    unique case (state_q)
                        ST_ARM:  state_d = start_edge ? ST_MEAS : ST_ARM;
                        ST_MEAS: state_d = stop_edge  ? ST_IDLE : ST_MEAS;
                        default: state_d = ST_ARM;
                    endcase
                end
                MODE_HOLD:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs of the state machine
    always_comb begin
        step    = 1'b0;
        run_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: step = 1'b0;
            ST_RUN: begin
                if (ctrl.mode == MODE_TIMER)      step = tick_en;
                else if (ctrl.mode == MODE_EVENT) step = start_edge;
            end
            ST_ARM:  step = start_edge & tick_en;
            ST_MEAS: begin
                step    = tick_en & ~stop_edge;
                run_clr = stop_edge;
            end
        endcase
        step = step & ctrl.run;
    end

    assign ovf = step && (cnt_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pre_wr && !ctrl.run) begin
            cnt_q <= pre_val;
        end else if (step) begin
            cnt_q <= (cnt_q == CNT_MAX) ? pre_q : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq_flag <= 1'b0;
        else if (ovf)     irq_flag <= 1'b1;
        else if (irq_clr) irq_flag <= 1'b0;
    end
endmodule

// File: rtl/tmr_evt_counter.sv
module tmr_evt_counter
    import tmr_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       pin_in,
    input  logic       tick_en,
    input  logic       irq_clr,
    output logic       irq_flag
);
    logic             pin_rise;
    logic             pin_fall;
    tmr_ctrl_t        ctrl_q;
    logic [WIDTH-1:0] pre_q;
    logic             pre_wr;
    logic [WIDTH-1:0] pre_val;
    logic [WIDTH-1:0] cnt_q;
    tmr_state_e       state_q;
    logic             run_clr;
    logic             ovf;

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(pin_in),
        .pin_rise (pin_rise),
        .pin_fall (pin_fall)
    );

    tmr_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cnt      (cnt_q),
        .run_clr  (run_clr),
        .ctrl_q   (ctrl_q),
        .pre_q    (pre_q),
        .pre_wr   (pre_wr),
        .pre_val  (pre_val)
    );

    tmr_core #(.WIDTH(WIDTH)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl_q),
        .tick_en (tick_en),
        .pin_rise(pin_rise),
        .pin_fall(pin_fall),
        .pre_q   (pre_q),
        .pre_wr  (pre_wr),
        .pre_val (pre_val),
        .irq_clr (irq_clr),
        .cnt_q   (cnt_q),
        .state_q (state_q),
        .run_clr (run_clr),
        .ovf     (ovf),
        .irq_flag(irq_flag)
    );
endmodule

// File: rtl/tmr_evt_counter_chk.sv
module tmr_evt_counter_chk
    import tmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic             tick_en,
    input logic             irq_clr,
    input logic             irq_flag,
    input logic [WIDTH-1:0] cnt,
    input logic [WIDTH-1:0] pre,
    input tmr_ctrl_t        ctrl,
    input tmr_state_e       state,
    input logic             run_clr,
    input logic             ovf
);
    localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && !irq_flag && !ctrl.run));

    // R3
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && ctrl.run && ctrl.mode == MODE_TIMER && tick_en && cnt != CNT_MAX)
        |=> cnt == $past(cnt) + 1'b1);

    // R5
    ovf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt == $past(pre) && irq_flag));

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R7
    pw_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_clr && !(bus_sel && bus_wr)) |=> (!ctrl.run && state == ST_IDLE));

    // R12
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run && !(bus_sel && bus_wr)) |=> $stable(cnt));
endmodule

bind tmr_evt_counter tmr_evt_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .tick_en (tick_en),
    .irq_clr (irq_clr),
    .irq_flag(irq_flag),
    .cnt     (cnt_q),
    .pre     (pre_q),
    .ctrl    (ctrl_q),
    .state   (state_q),
    .run_clr (run_clr),
    .ovf     (ovf)
);

// File: tb/sim_tmr_evt_counter.sv
module sim_tmr_evt_counter;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel0 = 1'b0, sel1 = 1'b0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata0, rdata1;
    logic       pin = 1'b0, tick = 1'b0, iclr = 1'b0;
    logic       irq0, irq1;

    int nchk = 0;
    int nfail = 0;

    always #(CLK_P/2) clk = ~clk;

    tmr_evt_counter u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel0), .bus_wr(wr), .bus_rd(rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata0),
        .pin_in(pin), .tick_en(tick), .irq_clr(iclr), .irq_flag(irq0)
    );

    tmr_evt_counter #(.WIDTH(8)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel1), .bus_wr(wr), .bus_rd(rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata1),
        .pin_in(pin), .tick_en(tick), .irq_clr(iclr), .irq_flag(irq1)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int inst, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel0 = (inst == 0); sel1 = (inst == 1); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel0 = 1'b0; sel1 = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_reg(input int inst, input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        sel0 = (inst == 0); sel1 = (inst == 1); rd = 1'b1; addr = a;
        #1 v = (inst == 0) ? rdata0 : rdata1;
        @(negedge clk);
        sel0 = 1'b0; sel1 = 1'b0; rd = 1'b0;
    endtask

    task automatic load16(input logic [15:0] v);
        wr_reg(0, 2'd0, v[7:0]);
        wr_reg(0, 2'd1, v[15:8]);
    endtask

    task automatic read16(output logic [15:0] v);
        logic [7:0] h, l;
        rd_reg(0, 2'd1, h);
        rd_reg(0, 2'd0, l);
        v = {h, l};
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // model of one counting step
    function automatic logic [15:0] next_cnt(input logic [15:0] c, input logic [15:0] p,
                                             input logic [15:0] mx);
        return (c == mx) ? p : c + 16'd1;
    endfunction

    initial begin
        logic [15:0] v16, exp16, pre;
        logic [7:0]  v8;
        logic        exp_irq;
        logic        prev_pin;
        int unsigned seed;
        seed = 32'h0000_5EED;
        void'($urandom(seed));

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: everything zero after reset (low buffer read first)
        rd_reg(0, 2'd0, v8);       chk("R1 buffer", v8, 0);
        read16(v16);               chk("R1 count", v16, 0);
        rd_reg(0, 2'd2, v8);       chk("R1 control", v8, 0);
        chk("R1 irq", irq0, 0);

        // R2: control layout readback
        wr_reg(0, 2'd2, 8'h05);
        rd_reg(0, 2'd2, v8);       chk("R2 control readback", v8, 8'h05);

        // R12: stopped timer ignores ticks
        wr_reg(0, 2'd2, 8'h01);
        tick = 1'b1; idle(20); tick = 1'b0;
        read16(v16);               chk("R12 stopped count", v16, 0);

        // R9: low write alone leaves counter, high write commits word
        wr_reg(0, 2'd0, 8'h34);
        rd_reg(0, 2'd1, v8);       chk("R9 low write no effect", v8, 0);
        wr_reg(0, 2'd0, 8'h34);
        wr_reg(0, 2'd1, 8'h12);
        read16(v16);               chk("R9 word load", v16, 16'h1234);

        // R3/R5: random tick streams from preloads near the top
        for (int r = 0; r < 3; r++) begin
            pre = 16'hFF00 | 16'($urandom_range(0, 255));
            load16(pre);
            exp16 = pre; exp_irq = irq0;
            wr_reg(0, 2'd2, 8'h09);
            for (int i = 0; i < 400; i++) begin
                @(negedge clk);
                tick = $urandom_range(0, 1) == 1;
                if (tick) begin
                    if (exp16 == 16'hFFFF) exp_irq = 1'b1;
                    exp16 = next_cnt(exp16, pre, 16'hFFFF);
                end
            end
            @(negedge clk); tick = 1'b0;
            wr_reg(0, 2'd2, 8'h01);
            read16(v16);           chk("R3 timer count", v16, exp16);
            chk("R5 overflow flag", irq0, exp_irq);
        end

        // R6: clear, then set wins over clear
        @(negedge clk); iclr = 1'b1; @(negedge clk); iclr = 1'b0;
        chk("R6 flag cleared", irq0, 0);
        load16(16'hFFFE);
        wr_reg(0, 2'd2, 8'h09);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); iclr = 1'b1;
        @(negedge clk); tick = 1'b0; iclr = 1'b0;
        chk("R6 set beats clear", irq0, 1);
        wr_reg(0, 2'd2, 8'h01);
        read16(v16);               chk("R5 reload value", v16, 16'hFFFE);

        // R9: preload write while running leaves counter, used at next reload
        load16(16'hFFF0);
        wr_reg(0, 2'd2, 8'h09);
        load16(16'h8000);
        read16(v16);               chk("R9 running load ignored", v16, 16'hFFF0);
        @(negedge clk); tick = 1'b1; idle(20); tick = 1'b0;
        wr_reg(0, 2'd2, 8'h01);
        read16(v16);               chk("R9 new preload on reload", v16, 16'h8004);

        // R4: event mode, both edges, random ticks ignored
        for (int e = 1; e >= 0; e--) begin
            load16(16'h0000);
            wr_reg(0, 2'd2, (e == 1) ? 8'h0C : 8'h08);
            idle(3);
            exp16 = 0; prev_pin = pin;
            for (int i = 0; i < 80; i++) begin
                @(negedge clk);
                pin  = $urandom_range(0, 1) == 1;
                tick = $urandom_range(0, 1) == 1;
                if (e == 1 && pin && !prev_pin) exp16++;
                if (e == 0 && !pin && prev_pin) exp16++;
                prev_pin = pin;
            end
            tick = 1'b0; idle(5);
            wr_reg(0, 2'd2, 8'h00);
            read16(v16);           chk(e == 1 ? "R4 rising events" : "R4 falling events", v16, exp16);
        end

        // R7: pulse width, active high
        @(negedge clk); pin = 1'b0; idle(4);
        load16(16'h0100);
        wr_reg(0, 2'd2, 8'h0E);
        idle(3); tick = 1'b1;
        pin = 1'b1; idle(37); pin = 1'b0; idle(5); tick = 1'b0;
        read16(v16);               chk("R7 high pulse width", v16, 16'h0125);
        rd_reg(0, 2'd2, v8);       chk("R7 run cleared", v8, 8'h06);

        // R8: later pulse ignored
        tick = 1'b1; pin = 1'b1; idle(10); pin = 1'b0; idle(5); tick = 1'b0;
        read16(v16);               chk("R8 held result", v16, 16'h0125);

        // R7: pulse width, active low
        pin = 1'b1; idle(4);
        wr_reg(0, 2'd2, 8'h0A);
        idle(3); tick = 1'b1;
        pin = 1'b0; idle(20); pin = 1'b1; idle(5); tick = 1'b0;
        read16(v16);               chk("R7 low pulse width", v16, 16'h0139);
        rd_reg(0, 2'd2, v8);       chk("R7 run cleared low", v8, 8'h02);

        // R10: high read snapshots the low byte
        load16(16'h12AB);
        rd_reg(0, 2'd1, v8);       chk("R10 high byte", v8, 8'h12);
        wr_reg(0, 2'd2, 8'h09);
        @(negedge clk); tick = 1'b1; idle(5); tick = 1'b0;
        wr_reg(0, 2'd2, 8'h01);
        rd_reg(0, 2'd0, v8);       chk("R10 snapshot low", v8, 8'hAB);
        read16(v16);               chk("R10 fresh word", v16, 16'h12B0);

        // R11: 8-bit variant
        wr_reg(1, 2'd0, 8'hF8);
        rd_reg(1, 2'd0, v8);       chk("R11 direct preload", v8, 8'hF8);
        wr_reg(1, 2'd2, 8'h09);
        @(negedge clk); tick = 1'b1; idle(10); tick = 1'b0;
        wr_reg(1, 2'd2, 8'h01);
        rd_reg(1, 2'd0, v8);       chk("R11 live count", v8, 8'hFA);
        chk("R11 overflow flag", irq1, 1);

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule